// File: doc/BRIEF.md
# Audio master clock ratio detector

This block sits beside the digital path of an audio DAC. It counts master clock cycles across each complete period of the frame (left/right) clock. It matches the count to one of six supported master-clock-to-sample-rate ratios and chooses the oversampling mode from the result. The normal ratios are 256, 384, 512 and 768; these cover sample rates from 8 kHz to 96 kHz. The low ratios are 128 and 192; these allow sample rates up to 192 kHz. At a low ratio the block asks for 64x oversampling and for the first interpolation stage to be skipped.

A second part runs from a free-running reference clock and watches whether the master clock is still alive. A toggle flop clocked by the master clock is brought into the reference domain. If it stops changing, the block declares the clock lost. It then raises a request that holds the filters and analogue path in reset with the output muted. When the master clock returns, the request drops, so the filters restart from a cleared state. The ratio outputs stand for configuration that must survive the outage, and they are left untouched.

The ratio outputs belong to the master clock domain. The loss and mute outputs belong to the reference clock domain.

Top module: `mclk_ratio_detect`

## Requirements
- R1: A frame period of N master clock cycles is classified within ±TOL (default 2) of a nominal ratio. The codes are 0=128, 1=192, 2=256, 3=384, 4=512 and 5=768, and the period is measured between rising edges of the frame clock.
- R2: A period outside every window, including any period of 2^CNT_W−1 cycles or more, gives code 7 and ratio_valid low. Any classified code gives ratio_valid high.
- R3: The ratio outputs change only when two consecutive measured periods give the same classification. A single differing period leaves them unchanged. The first rising edge after reset only starts the count.
- R4: mode_64x and bypass_stage1 are both high exactly when the applied ratio code is 0 or 1.
- R5: After reset the outputs are: ratio_code 7, ratio_valid 0, mode_64x 0, bypass_stage1 0 and clk_lost 0.
- R6: clk_lost rises once the synchronised master clock toggle has been unchanged for LOSS_CYC (default 64) reference cycles. It does not rise earlier.
- R7: flt_reset_mute is high whenever clk_lost is high. Both drop within a few reference cycles after master clock activity resumes.
- R8: A master clock loss and its recovery leave ratio_code, ratio_valid and the mode flags unchanged.
- R9: flt_reset_mute is high from reset until the first master clock activity is seen in the reference domain, even before any loss is declared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master system clock |
| ref_clk | input | 1 | Free-running reference clock for the loss monitor |
| rst | input | 1 | Synchronous active-high reset, applied in both clock domains |
| lrclk | input | 1 | Frame (left/right) clock, asynchronous, synchronised inside |
| ratio_code | output | 3 | Confirmed ratio code (mclk domain), 7 = none |
| ratio_valid | output | 1 | Confirmed code is a supported ratio (mclk domain) |
| mode_64x | output | 1 | 64x oversampling selected (mclk domain) |
| bypass_stage1 | output | 1 | Skip the first interpolation stage (mclk domain) |
| clk_lost | output | 1 | Master clock declared absent (ref_clk domain) |
| flt_reset_mute | output | 1 | Filter/analogue reset and mute request (ref_clk domain) |

## Verification
The assertions take several things for granted:
- Every frame period is a whole number of master clock cycles.
- The reference clock runs faster than the master clock, so each toggle of the master clock toggle flop is sampled.
- Reset is held long enough to reach both clock domains.

The stimulus meets these conditions. It moves the frame clock only on master clock falling edges, and it changes the period only at frame boundaries. The reference clock runs at a 6 ns period against a 10 ns master clock. Reset stays high for many edges of both clocks. The master clock is stopped and restarted only by gating it at a level, so no runt pulses appear.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
  localparam int N_RATIOS = 6;

  typedef enum logic [2:0] {
    RATIO_128  = 3'd0,
    RATIO_192  = 3'd1,
    RATIO_256  = 3'd2,
    RATIO_384  = 3'd3,
    RATIO_512  = 3'd4,
    RATIO_768  = 3'd5,
    RATIO_NONE = 3'd7
  } ratio_e;

  // Even index: 128 shifted, odd index: 192 shifted -> 128,192,256,384,512,768
  function automatic int nominal_ratio(input int idx);
    return ((idx % 2) == 0) ? (128 << (idx / 2)) : (192 << (idx / 2));
  endfunction
endpackage

// File: rtl/mrd_period_counter.sv
module mrd_period_counter #(
  parameter int CNT_W = 11
) (
  input  logic             mclk,
  input  logic             rst,
  input  logic             lrclk,
  output logic [CNT_W-1:0] meas,
  output logic             meas_vld
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [2:0]       lr_sync;
  logic             rise;
  logic             armed;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge mclk) begin
    if (rst) lr_sync <= '0;
    else     lr_sync <= {lr_sync[1:0], lrclk};
  end

  assign rise = lr_sync[1] & ~lr_sync[2];

  always_ff @(posedge mclk) begin
    if (rst) begin
      cnt      <= '0;
      armed    <= 1'b0;
      meas     <= '0;
      meas_vld <= 1'b0;
    end else begin
      meas_vld <= 1'b0;
      if (rise) begin
        cnt   <= CNT_ONE;
        armed <= 1'b1;
        if (armed) begin
          meas     <= cnt;
          meas_vld <= 1'b1;
        end
      end else if (cnt != CNT_MAX) begin
        cnt <= cnt + CNT_ONE;
      end
    end
  end

  // R1
  meas_spacing_chk: assert property (@(posedge mclk) disable iff (rst)
    meas_vld |=> !meas_vld);

  // R3
  armed_count_chk: assert property (@(posedge mclk) disable iff (rst)
    meas_vld |-> (armed && meas != '0));
endmodule

// File: rtl/mrd_ratio_classifier.sv
module mrd_ratio_classifier
  import mrd_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int TOL   = 2
) (
  input  logic             mclk,
  input  logic             rst,
  input  logic [CNT_W-1:0] meas,
  input  logic             meas_vld,
  output logic [2:0]       ratio_code,
  output logic             ratio_valid,
  output logic             mode_64x,
  output logic             bypass_stage1
);
  logic [N_RATIOS-1:0] hit;
  ratio_e              cls;
  ratio_e              pend;
  logic                pend_have;
  ratio_e              code_q;

  for (genvar gi = 0; gi < N_RATIOS; gi++) begin : g_win
    localparam logic [CNT_W-1:0] LO = CNT_W'(nominal_ratio(gi) - TOL);
    localparam logic [CNT_W-1:0] HI = CNT_W'(nominal_ratio(gi) + TOL);
    assign hit[gi] = (meas >= LO) && (meas <= HI);
  end

  always_comb begin
    cls = RATIO_NONE;
    for (int i = 0; i < N_RATIOS; i++) begin
      if (hit[i]) cls = ratio_e'(3'(i));
    end
  end

  always_ff @(posedge mclk) begin
    if (rst) begin
      pend          <= RATIO_NONE;
      pend_have     <= 1'b0;
      code_q        <= RATIO_NONE;
      ratio_valid   <= 1'b0;
      mode_64x      <= 1'b0;
      bypass_stage1 <= 1'b0;
    end else if (meas_vld) begin
      pend      <= cls;
      pend_have <= 1'b1;
      if (pend_have && pend == cls) begin
        code_q        <= cls;
        ratio_valid   <= (cls != RATIO_NONE);
        mode_64x      <= (cls == RATIO_128) || (cls == RATIO_192);
        bypass_stage1 <= (cls == RATIO_128) || (cls == RATIO_192);
      end
    end
  end

  assign ratio_code = code_q;

  // R3
  code_update_chk: assert property (@(posedge mclk) disable iff (rst)
    (ratio_code != $past(ratio_code)) |-> $past(meas_vld));

  // R4
  mode_valid_chk: assert property (@(posedge mclk) disable iff (rst)
    mode_64x |-> (ratio_valid && ratio_code < 3'd2));

  // R2
  valid_code_chk: assert property (@(posedge mclk) disable iff (rst)
    !ratio_valid |-> (ratio_code == 3'd7));
endmodule

// File: rtl/mrd_loss_monitor.sv
module mrd_loss_monitor #(
  parameter int LOSS_CYC = 64
) (
  input  logic mclk,
  input  logic ref_clk,
  input  logic rst,
  output logic clk_lost,
  output logic flt_reset_mute
);
  localparam int IDLE_W = $clog2(LOSS_CYC + 1);
  localparam logic [IDLE_W-1:0] IDLE_MAX  = IDLE_W'(LOSS_CYC);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(LOSS_CYC - 1);
  localparam logic [IDLE_W-1:0] IDLE_ONE  = IDLE_W'(1);

  logic              tgl;
  logic [2:0]        tgl_sync;
  logic              chg;
  logic [IDLE_W-1:0] idle_cnt;

  always_ff @(posedge mclk) begin
    if (rst) tgl <= 1'b0;
    else     tgl <= ~tgl;
  end

  always_ff @(posedge ref_clk) begin
    if (rst) tgl_sync <= '0;
    else     tgl_sync <= {tgl_sync[1:0], tgl};
  end

  assign chg = tgl_sync[1] ^ tgl_sync[2];

  always_ff @(posedge ref_clk) begin
    if (rst) begin
      idle_cnt       <= '0;
      clk_lost       <= 1'b0;
      flt_reset_mute <= 1'b1;
    end else if (chg) begin
      idle_cnt       <= '0;
      clk_lost       <= 1'b0;
      flt_reset_mute <= 1'b0;
    end else begin
      if (idle_cnt != IDLE_MAX) idle_cnt <= idle_cnt + IDLE_ONE;
      if (idle_cnt == IDLE_LAST) begin
        clk_lost       <= 1'b1;
        flt_reset_mute <= 1'b1;
      end
    end
  end

  // R7
  lost_mutes_chk: assert property (@(posedge ref_clk) disable iff (rst)
    clk_lost |-> flt_reset_mute);

  // R7
  activity_release_chk: assert property (@(posedge ref_clk) disable iff (rst)
    chg |=> (!clk_lost && !flt_reset_mute));

  // R6
  lost_window_chk: assert property (@(posedge ref_clk) disable iff (rst)
    clk_lost |-> (idle_cnt == IDLE_MAX));
endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect #(
  parameter int CNT_W    = 11,
  parameter int TOL      = 2,
  parameter int LOSS_CYC = 64
) (
  input  logic       mclk,
  input  logic       ref_clk,
  input  logic       rst,
  input  logic       lrclk,
  output logic [2:0] ratio_code,
  output logic       ratio_valid,
  output logic       mode_64x,
  output logic       bypass_stage1,
  output logic       clk_lost,
  output logic       flt_reset_mute
);
  logic [CNT_W-1:0] meas;
  logic             meas_vld;

  mrd_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .mclk     (mclk),
    .rst      (rst),
    .lrclk    (lrclk),
    .meas     (meas),
    .meas_vld (meas_vld)
  );

  mrd_ratio_classifier #(.CNT_W(CNT_W), .TOL(TOL)) u_cls (
    .mclk          (mclk),
    .rst           (rst),
    .meas          (meas),
    .meas_vld      (meas_vld),
    .ratio_code    (ratio_code),
    .ratio_valid   (ratio_valid),
    .mode_64x      (mode_64x),
    .bypass_stage1 (bypass_stage1)
  );

  mrd_loss_monitor #(.LOSS_CYC(LOSS_CYC)) u_loss (
    .mclk           (mclk),
    .ref_clk        (ref_clk),
    .rst            (rst),
    .clk_lost       (clk_lost),
    .flt_reset_mute (flt_reset_mute)
  );

  // R4
  bypass_pair_chk: assert property (@(posedge mclk) disable iff (rst)
    bypass_stage1 |-> mode_64x);
endmodule

// File: tb/mclk_ratio_detect_tb.sv
module mclk_ratio_detect_tb;
  localparam int CLK_PERIOD = 10;
  localparam int REF_PERIOD = 6;

  logic       mclk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       mclk_en = 1'b1;
  logic       rst = 1'b1;
  logic       lrclk = 1'b0;
  logic [2:0] ratio_code;
  logic       ratio_valid, mode_64x, bypass_stage1, clk_lost, flt_reset_mute;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  mclk_ratio_detect u_dut (
    .mclk(mclk), .ref_clk(ref_clk), .rst(rst), .lrclk(lrclk),
    .ratio_code(ratio_code), .ratio_valid(ratio_valid), .mode_64x(mode_64x),
    .bypass_stage1(bypass_stage1), .clk_lost(clk_lost), .flt_reset_mute(flt_reset_mute)
  );

  always begin
    #(CLK_PERIOD / 2);
    if (mclk_en) mclk = ~mclk;
  end

  always #(REF_PERIOD / 2) ref_clk = ~ref_clk;

  function automatic int nom(input int idx);
    int base;
    base = ((idx % 2) == 0) ? 128 : 192;
    return base * (1 << (idx / 2));
  endfunction

  function automatic int exp_code(input int n);
    for (int i = 0; i < 6; i++) begin
      if (n >= nom(i) - 2 && n <= nom(i) + 2) return i;
    end
    return 7;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_frames(input int n, input int k);
    for (int f = 0; f < k; f++) begin
      for (int c = 0; c < n; c++) begin
        @(negedge mclk);
        lrclk = (c < n / 2);
      end
    end
  endtask

  task automatic ref_wait(input int k);
    for (int i = 0; i < k; i++) @(negedge ref_clk);
  endtask

  task automatic check_ratio(input int n);
    int e;
    e = exp_code(n);
    chk((e == 7) ? "R2 code" : "R1 code", ratio_code, e);
    chk("R2 valid", ratio_valid, (e != 7) ? 1 : 0);
    chk("R4 mode_64x", mode_64x, (e < 2) ? 1 : 0);
    chk("R4 bypass_stage1", bypass_stage1, (e < 2) ? 1 : 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // Reset with both clocks running, then stop mclk before release
    repeat (20) @(negedge mclk);
    mclk_en = 1'b0;
    ref_wait(5);
    rst = 1'b0;
    ref_wait(20);
    // R5 reset state
    chk("R5 ratio_code", ratio_code, 7);
    chk("R5 ratio_valid", ratio_valid, 0);
    chk("R5 mode_64x", mode_64x, 0);
    chk("R5 bypass_stage1", bypass_stage1, 0);
    chk("R5 clk_lost", clk_lost, 0);
    // R9 mute held before any mclk activity
    chk("R9 mute before activity", flt_reset_mute, 1);
    mclk_en = 1'b1;
    ref_wait(10);
    chk("R9 mute released", flt_reset_mute, 0);

    // R3 first edge only arms, one measurement is not enough
    run_frames(256, 2);
    chk("R3 unconfirmed", ratio_code, 7);
    run_frames(256, 1);
    chk("R3 confirmed", ratio_code, 2);

    // R1 R2 R4 sweep around every nominal ratio
    for (int r = 0; r < 6; r++) begin
      for (int d = -3; d <= 3; d++) begin
        run_frames(nom(r) + d, 3);
        check_ratio(nom(r) + d);
      end
    end
    run_frames(20, 3);   check_ratio(20);
    run_frames(1000, 3); check_ratio(1000);
    run_frames(2100, 3);
    chk("R2 saturated code", ratio_code, 7);
    chk("R2 saturated valid", ratio_valid, 0);

    // R3 single glitch frame ignored, change needs two agreeing frames
    run_frames(256, 3);
    chk("R3 base", ratio_code, 2);
    run_frames(384, 1);
    run_frames(256, 1);
    chk("R3 glitch ignored", ratio_code, 2);
    run_frames(256, 1);
    run_frames(384, 2);
    chk("R3 one new frame", ratio_code, 2);
    run_frames(384, 1);
    chk("R3 two new frames", ratio_code, 3);

    // R6 R7 R8 loss and recovery
    run_frames(512, 3);
    chk("R8 pre-loss", ratio_code, 4);
    @(negedge mclk);
    mclk_en = 1'b0;
    ref_wait(40);
    chk("R6 not yet lost", clk_lost, 0);
    ref_wait(40);
    chk("R6 lost", clk_lost, 1);
    chk("R7 mute while lost", flt_reset_mute, 1);
    chk("R8 code kept", ratio_code, 4);
    chk("R8 valid kept", ratio_valid, 1);
    mclk_en = 1'b1;
    ref_wait(8);
    chk("R7 lost cleared", clk_lost, 0);
    chk("R7 mute cleared", flt_reset_mute, 0);
    run_frames(512, 1);
    chk("R8 code after recovery", ratio_code, 4);
    run_frames(512, 2);
    chk("R8 code steady", ratio_code, 4);
    chk("R4 mode after recovery", mode_64x, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule